// File: doc/BRIEF.md
# Programmable SCL High-Period Timer

This block keeps two configuration counts for a standard-speed serial clock line: the number of system clocks the line stays high and the number it stays low. While the controller is enabled it drives the SCL output from a phase counter. The counter starts a high phase of the programmed high count and then a low phase of the programmed low count, and it repeats this for as long as the enable stays at 1. While the controller is disabled the line is released and held high. The counter waits until the next rising edge of the enable.

Software programs the counts through a simple write port with a separate strobe for each count. The block takes a write only while the enable is 0. It replaces any value below the legal minimum with the minimum. A read port returns whichever stored count a select input picks. Both counts have to be programmed before the first bus transaction, because the phase counter loads them only when the enable rises.

Top module: `scl_high_timer`

## Requirements
- R1: After reset the high count reads 0x029B (parameter HIGH_RST), the low count reads parameter LOW_RST, and sclOut is 1.
- R2: With ctrlEn at 0, a wrHigh pulse carrying a value of 6 or more stores that value, and the value can be read back on the cycle after the write edge.
- R3: With ctrlEn at 0, a wrHigh pulse carrying a value below 6 (0 included) stores 6, and a read returns 6.
- R4: While ctrlEn is 1, wrHigh and wrLow pulses leave both stored counts unchanged.
- R5: While ctrlEn is 1, sclOut is 1 for exactly the high count of clocks, then 0 for exactly the low count, and this repeats. The first high phase begins at the clock edge that first samples ctrlEn as 1.
- R6: wrLow follows the same rules for the low count: a minimum of 6 with clamping, and it is accepted only while ctrlEn is 0.
- R7: While ctrlEn is 0, sclOut is 1 from the first clock edge that samples it as 0. A later rise of ctrlEn restarts a full high phase.
- R8: rdData shows the high count when rdSel is 0 and the low count when rdSel is 1, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlEn | input | 1 | Controller enable; locks the counts and runs the clock |
| wrHigh | input | 1 | Write strobe for the high count |
| wrLow | input | 1 | Write strobe for the low count |
| wrData | input | CNT_W | Write value |
| rdSel | input | 1 | Read select: 0 high count, 1 low count |
| rdData | output | CNT_W | Selected stored count |
| sclOut | output | 1 | Generated serial clock |

## Verification
The bench builds the block with the full 16-bit count width and the default high reset value 0x029B. It overrides the low reset value to 16, so that a complete period at the reset values takes well under a thousand clocks. Each write port is swept exhaustively over 0 to 40, which covers every clamped value and the boundary at 6, along with the all-ones value. Several short high and low pairs near the minimum are each run for three complete periods and checked clock by clock against the period arithmetic. The bench also disables the block mid-phase and re-enables it.

// File: rtl/sht_pkg.sv
package sht_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic [1:0] load;     // [0] high count, [1] low count
    logic       run;
    logic       restart;
  } ctlStrobes_t;
endpackage

// File: rtl/sht_ctrl.sv
module sht_ctrl
  import sht_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlEn,
  input  logic        wrHigh,
  input  logic        wrLow,
  output ctlStrobes_t strb
);
  logic enPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= ctrlEn;
  end

  always_comb begin
    strb.load[0] = wrHigh & ~ctrlEn;
    strb.load[1] = wrLow & ~ctrlEn;
    strb.run     = ctrlEn;
    strb.restart = ctrlEn & ~enPrev;
  end
endmodule

// File: rtl/sht_datapath.sv
module sht_datapath
  import sht_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int HIGH_RST = 16'h029B,
  parameter int LOW_RST  = 16'h0335,
  parameter int HIGH_MIN = 6,
  parameter int LOW_MIN  = 6
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] highVal,
  output logic [CNT_W-1:0] lowVal,
  output logic             sclOut
);
  localparam int NCFG = 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cfg [NCFG];
  logic [CNT_W-1:0] cnt;
  logic             phaseHigh;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    localparam logic [CNT_W-1:0] RSTV = CNT_W'((g == 0) ? HIGH_RST : LOW_RST);
    localparam logic [CNT_W-1:0] MINV = CNT_W'((g == 0) ? HIGH_MIN : LOW_MIN);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            cfg[g] <= RSTV;
      else if (strb.load[g]) cfg[g] <= (wrData < MINV) ? MINV : wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseHigh <= 1'b1;
      cnt       <= '0;
    end else if (!strb.run) begin
      phaseHigh <= 1'b1;
      cnt       <= '0;
    end else if (strb.restart) begin
      phaseHigh <= 1'b1;
      cnt       <= cfg[0] - ONE;
    end else if (cnt == '0) begin
      phaseHigh <= ~phaseHigh;
      cnt       <= phaseHigh ? (cfg[1] - ONE) : (cfg[0] - ONE);
    end else begin
      cnt <= cnt - ONE;
    end
  end

  assign highVal = cfg[0];
  assign lowVal  = cfg[1];
  assign rdData  = rdSel ? cfg[1] : cfg[0];
  assign sclOut  = phaseHigh;
endmodule

// File: rtl/scl_high_timer.sv
module scl_high_timer
  import sht_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int HIGH_RST = 16'h029B,
  parameter int LOW_RST  = 16'h0335,
  parameter int HIGH_MIN = 6,
  parameter int LOW_MIN  = 6
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlEn,
  input  logic             wrHigh,
  input  logic             wrLow,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic             sclOut
);
  ctlStrobes_t      strb;
  logic [CNT_W-1:0] highVal;
  logic [CNT_W-1:0] lowVal;

  sht_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn),
    .wrHigh(wrHigh), .wrLow(wrLow), .strb(strb)
  );

  sht_datapath #(
    .CNT_W(CNT_W), .HIGH_RST(HIGH_RST), .LOW_RST(LOW_RST),
    .HIGH_MIN(HIGH_MIN), .LOW_MIN(LOW_MIN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .highVal(highVal),
    .lowVal(lowVal), .sclOut(sclOut)
  );
endmodule

// File: rtl/sht_checker.sv
module sht_checker #(
  parameter int CNT_W    = 16,
  parameter int HIGH_MIN = 6,
  parameter int LOW_MIN  = 6
)(
  input logic             clk,
  input logic             rstN,
  input logic             ctrlEn,
  input logic             wrHigh,
  input logic             wrLow,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] highVal,
  input logic [CNT_W-1:0] lowVal,
  input logic             sclOut
);
  // R3
  min_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (highVal >= CNT_W'(HIGH_MIN)) && (lowVal >= CNT_W'(LOW_MIN)));

  // R2
  write_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrHigh && !ctrlEn && wrData >= CNT_W'(HIGH_MIN)) |=> (highVal == $past(wrData)));

  // R4
  lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlEn |=> ($stable(highVal) && $stable(lowVal)));

  // R6
  low_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrLow && !ctrlEn && wrData < CNT_W'(LOW_MIN)) |=> (lowVal == CNT_W'(LOW_MIN)));

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> sclOut);

  // R5
  start_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlEn) |=> sclOut);
endmodule

bind scl_high_timer sht_checker #(
  .CNT_W(CNT_W), .HIGH_MIN(HIGH_MIN), .LOW_MIN(LOW_MIN)
) u_chk (
  .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .wrHigh(wrHigh), .wrLow(wrLow),
  .wrData(wrData), .highVal(highVal), .lowVal(lowVal), .sclOut(sclOut)
);

// File: tb/scl_high_timer_bench.sv
`timescale 1ns/1ps
module scl_high_timer_bench;
  localparam int CNT_W = 16;
  localparam int LOWR  = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             ctrlEn = 1'b0;
  logic             wrHigh = 1'b0;
  logic             wrLow = 1'b0;
  logic [CNT_W-1:0] wrData = '0;
  logic             rdSel = 1'b0;
  logic [CNT_W-1:0] rdData;
  logic             sclOut;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  scl_high_timer #(.CNT_W(CNT_W), .LOW_RST(LOWR)) u_scl_high_timer (
    .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .wrHigh(wrHigh), .wrLow(wrLow),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .sclOut(sclOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic readCnt(input logic sel, output int v);
    rdSel = sel;
    #1;
    v = int'(rdData);
  endtask

  task automatic writeCnt(input logic isLow, input int v);
    @(negedge clk);
    wrData = CNT_W'(v);
    wrHigh = ~isLow;
    wrLow  = isLow;
    @(negedge clk);
    wrHigh = 1'b0;
    wrLow  = 1'b0;
  endtask

  // Enable, compare sclOut every clock against period arithmetic
  task automatic runPattern(input string req, input int h, input int l, input int periods);
    int firstBad = -1;
    int actBad = 0;
    int expBad = 0;
    @(negedge clk);
    ctrlEn = 1'b1;
    for (int i = 0; i < periods * (h + l); i++) begin
      @(negedge clk);
      if ((sclOut != ((i % (h + l)) < h)) && firstBad < 0) begin
        firstBad = i;
        actBad = int'(sclOut);
        expBad = int'((i % (h + l)) < h);
      end
    end
    if (firstBad >= 0) $display("  mismatch at clock %0d of h=%0d l=%0d", firstBad, h, l);
    check(req, actBad, expBad);
    ctrlEn = 1'b0;
    @(negedge clk);
    check("R7", int'(sclOut), 1);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int v;
    int hv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readCnt(1'b0, v); check("R1", v, 16'h029B);
    readCnt(1'b1, v); check("R1", v, LOWR);
    check("R1", int'(sclOut), 1);
    // R1, R5 period at reset values
    runPattern("R5", 16'h029B, LOWR, 2);

    // R2, R3, R8 high-count sweep
    for (int w = 0; w <= 40; w++) begin
      writeCnt(1'b0, w);
      readCnt(1'b0, v);
      check((w < 6) ? "R3" : "R2", v, (w < 6) ? 6 : w);
    end
    writeCnt(1'b0, 16'hFFFF);
    readCnt(1'b0, v); check("R2", v, 16'hFFFF);
    readCnt(1'b1, v); check("R8", v, LOWR);

    // R6 low-count sweep
    for (int w = 0; w <= 40; w++) begin
      writeCnt(1'b1, w);
      readCnt(1'b1, v);
      check("R6", v, (w < 6) ? 6 : w);
    end
    readCnt(1'b0, v); check("R8", v, 16'hFFFF);

    // R5 short periods near the minimum
    for (int hi = 6; hi <= 9; hi++) begin
      for (int lo = 6; lo <= 10; lo += 4) begin
        writeCnt(1'b0, hi);
        writeCnt(1'b1, lo);
        runPattern("R5", hi, lo, 3);
      end
    end

    // R4 writes while enabled are dropped
    writeCnt(1'b0, 7);
    writeCnt(1'b1, 8);
    @(negedge clk);
    ctrlEn = 1'b1;
    writeCnt(1'b0, 30);
    writeCnt(1'b1, 3);
    readCnt(1'b0, hv); check("R4", hv, 7);
    readCnt(1'b1, v);  check("R4", v, 8);
    // R7 disable mid-phase, then re-enable restarts a full high phase
    @(negedge clk);
    ctrlEn = 1'b0;
    @(negedge clk);
    check("R7", int'(sclOut), 1);
    readCnt(1'b0, v); check("R4", v, 7);
    runPattern("R7", 7, 8, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule